// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a CPU and main memory on a word-addressed bus with a 20-bit address and 16-bit data words. Each CPU address is split into a set index and a tag. Every set holds two ways. Each way keeps a tag, one data word, a valid flag and a modified (dirty) flag. The two stored tags of the selected set are compared with the incoming tag in parallel. A match in either way is a hit.

Read hits return the stored word in the same cycle. Write hits change only the cached copy and mark that way modified. On a miss the block stalls the CPU and picks a victim way: an empty way if the set has one, otherwise the way that one per-set recency bit marks as least recently used. If the victim is modified, the block first writes it back through a request/acknowledge port on the memory side. It then reads the missed word, installs it clean, and retries the lookup. The retry completes the access as a hit. For a write miss, the retry applies the write and sets the modified flag.

The CPU asserts `cpu_req` and holds the address, direction and write data until it sees `cpu_ready` high at a rising clock edge. That edge completes the access.

Top module: `cache2w_wb`

## Requirements
- R1: After reset every way is empty, so the first access to any set is a miss that issues a memory read.
- R2: A read hit raises `cpu_ready` in the cycle the request is presented, returns the stored word on `cpu_rdata` and makes no memory request.
- R3: The set index is `cpu_addr[9:0]` and the tag is `cpu_addr[19:10]`. Two addresses with the same index and different tags are held at once, one per way, and at most one way matches a lookup.
- R4: A write hit completes with no memory traffic. A later read of that address returns the new word, and main memory keeps its old value.
- R5: On a miss whose victim is empty or unmodified, the only memory transaction is one read (`mem_we`=0) at `cpu_addr`. When it is acknowledged, the line is installed and the CPU access completes on the next cycle.
- R6: On a miss whose victim is modified, a memory write of the victim word to address {victim tag, index} happens first. The read of the missed address follows at once.
- R7: The victim is an empty way if one exists, taking way 0 before way 1. Otherwise it is the least recently used way, where every hit and every fill makes the other way of that set the least recent.
- R8: A write miss first fills the line from memory, then applies the CPU word and marks the way modified. A later eviction of that line writes the CPU word back.
- R9: `cpu_ready` stays low for every cycle of miss service, from the miss until the line is installed.
- R10: Once `mem_req` is raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until the cycle in which `mem_ack` is high.
- R11: A line installed by a fill is unmodified. Evicting it without an intervening write causes no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until completion |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 20 | Word address: tag in [19:10], index in [9:0] |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid when a read completes |
| cpu_ready | output | 1 | High when idle or on a hit; low while a miss is serviced |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 20 | Memory word address |
| mem_wdata | output | 16 | Write-back data |
| mem_rdata | input | 16 | Refill data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge ending a memory transaction |

## Verification
The properties rely on the CPU keeping `cpu_addr`, `cpu_we` and `cpu_wdata` unchanged while a request waits. They also rely on memory answering each request with exactly one single-cycle acknowledge. The refill-address and completion properties would not hold without this. The bench drives a request and leaves it untouched until it observes `cpu_ready`. Its memory model raises `mem_ack` for exactly one cycle after a fixed latency, and never while `mem_req` is low. The accesses form a sequence in one set that drives the victim choice through empty ways, a clean least-recent way and a modified least-recent way. A second set is used for the write-miss case, and the top index is also touched.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;
    localparam int N_WAYS = 2;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2
    } cstate_e;

    typedef struct packed {
        cstate_e st;
        logic    vic;
    } ctl_s;
endpackage

// File: rtl/cache_way_store.sv
`timescale 1ns/1ps
module cache_way_store #(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_dirty
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [DATA_W-1:0] data_mem [SETS];
    logic [SETS-1:0]   valid_d, valid_q;
    logic [SETS-1:0]   dirty_d, dirty_q;

    // flag next state: a write always leaves the entry valid
    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (wr_en) begin
            valid_d[idx] = 1'b1;
            dirty_d[idx] = wr_dirty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    // payload arrays need no reset; the valid flag guards them
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[idx]  <= wr_tag;
            data_mem[idx] <= wr_data;
        end
    end

    assign rd_tag   = tag_mem[idx];
    assign rd_data  = data_mem[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
endmodule

// File: rtl/cache_lru_bits.sv
`timescale 1ns/1ps
module cache_lru_bits #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             upd_en,
    input  logic             upd_val,
    output logic             lru_way
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] lru_d, lru_q;

    always_comb begin
        lru_d = lru_q;
        if (upd_en) lru_d[idx] = upd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lru_q <= '0;
        else        lru_q <= lru_d;
    end

    assign lru_way = lru_q[idx];
endmodule

// File: rtl/cache_tag_match.sv
`timescale 1ns/1ps
module cache_tag_match
    import cache_pkg::*;
#(
    parameter int TAG_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic [TAG_W-1:0]               key,
    input  logic [N_WAYS-1:0][TAG_W-1:0]   tags,
    input  logic [N_WAYS-1:0]              valids,
    input  logic [N_WAYS-1:0][DATA_W-1:0]  datas,
    output logic [N_WAYS-1:0]              hit_vec,
    output logic                           hit_any,
    output logic                           hit_way,
    output logic [DATA_W-1:0]              hit_data
);
    // one comparator per way, all evaluated in parallel
    for (genvar g = 0; g < N_WAYS; g++) begin : g_cmp
        assign hit_vec[g] = valids[g] && (tags[g] == key);
    end

    assign hit_any  = |hit_vec;
    assign hit_way  = hit_vec[1];
    assign hit_data = datas[hit_way];
endmodule

// File: rtl/cache_victim_pick.sv
`timescale 1ns/1ps
module cache_victim_pick
    import cache_pkg::*;
(
    input  logic [N_WAYS-1:0] valids,
    input  logic              lru_way,
    output logic              victim
);
    always_comb begin
        if (!valids[0])      victim = 1'b0;
        else if (!valids[1]) victim = 1'b1;
        else                 victim = lru_way;
    end
endmodule

// File: rtl/cache2w_wb.sv
`timescale 1ns/1ps
module cache2w_wb
    import cache_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    assign idx = cpu_addr[IDX_W-1:0];
    assign tag = cpu_addr[ADDR_W-1:IDX_W];

    logic [N_WAYS-1:0][TAG_W-1:0]  w_tag;
    logic [N_WAYS-1:0][DATA_W-1:0] w_data;
    logic [N_WAYS-1:0]             w_valid;
    logic [N_WAYS-1:0]             w_dirty;
    logic [N_WAYS-1:0]             way_we;
    logic [DATA_W-1:0]             wr_data;
    logic                          wr_dirty;

    logic [N_WAYS-1:0] hit_vec;
    logic              hit_any;
    logic              hit_way;
    logic [DATA_W-1:0] hit_data;
    logic              lru_way;
    logic              lru_we;
    logic              lru_val;
    logic              victim;

    ctl_s ctl_d, ctl_q;

    for (genvar g = 0; g < N_WAYS; g++) begin : g_way
        cache_way_store #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W),
            .DATA_W(DATA_W)
        ) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .idx     (idx),
            .wr_en   (way_we[g]),
            .wr_tag  (tag),
            .wr_data (wr_data),
            .wr_dirty(wr_dirty),
            .rd_tag  (w_tag[g]),
            .rd_data (w_data[g]),
            .rd_valid(w_valid[g]),
            .rd_dirty(w_dirty[g])
        );
    end

    cache_tag_match #(
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_match (
        .key     (tag),
        .tags    (w_tag),
        .valids  (w_valid),
        .datas   (w_data),
        .hit_vec (hit_vec),
        .hit_any (hit_any),
        .hit_way (hit_way),
        .hit_data(hit_data)
    );

    cache_lru_bits #(.IDX_W(IDX_W)) u_lru (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (idx),
        .upd_en (lru_we),
        .upd_val(lru_val),
        .lru_way(lru_way)
    );

    cache_victim_pick u_vic (
        .valids (w_valid),
        .lru_way(lru_way),
        .victim (victim)
    );

    assign cpu_rdata = hit_data;

    always_comb begin
        ctl_d     = ctl_q;
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cpu_addr;
        mem_wdata = '0;
        way_we    = '0;
        wr_data   = cpu_wdata;
        wr_dirty  = 1'b1;
        lru_we    = 1'b0;
        lru_val   = 1'b0;
        unique case (ctl_q.st)
            ST_LOOKUP: begin
                cpu_ready = !cpu_req || hit_any;
                if (cpu_req && hit_any) begin
                    lru_we  = 1'b1;
                    lru_val = ~hit_way;
                    if (cpu_we) way_we[hit_way] = 1'b1;
                end else if (cpu_req) begin
                    ctl_d.vic = victim;
                    ctl_d.st  = (w_valid[victim] && w_dirty[victim]) ? ST_EVICT : ST_REFILL;
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {w_tag[ctl_q.vic], idx};
                mem_wdata = w_data[ctl_q.vic];
                if (mem_ack) ctl_d.st = ST_REFILL;
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    way_we[ctl_q.vic] = 1'b1;
                    wr_data  = mem_rdata;
                    wr_dirty = 1'b0;
                    lru_we   = 1'b1;
                    lru_val  = ~ctl_q.vic;
                    ctl_d.st = ST_LOOKUP;
                end
            end
            default: ctl_d.st = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_LOOKUP, vic: 1'b0};
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/cache2w_wb_chk.sv
`timescale 1ns/1ps
module cache2w_wb_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [1:0]        hit_vec
);
    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    assert_wb_then_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

    assert_refill_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> mem_addr == cpu_addr);

    assert_done_after_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack && cpu_req |=> !mem_req && cpu_ready);

    assert_one_way_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

bind cache2w_wb cache2w_wb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_addr (cpu_addr),
    .cpu_ready(cpu_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .hit_vec  (hit_vec)
);

// File: tb/sim_cache2w_wb.sv
`timescale 1ns/1ps
module sim_cache2w_wb;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_ready;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;

    always #10 clk = ~clk;

    cache2w_wb u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    typedef struct packed {
        logic          we;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } txn_t;

    int            n_run = 0;
    int            n_bad = 0;
    int            stall = 0;
    logic [DW-1:0] exp_q [$];
    txn_t          log_q [$];
    logic [DW-1:0] mem_img  [logic [AW-1:0]];
    logic [DW-1:0] cpu_view [logic [AW-1:0]];

    function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
        return a[DW-1:0] ^ 16'hA5A5;
    endfunction

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return mem_img.exists(a) ? mem_img[a] : dflt(a);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: fixed latency, single-cycle acknowledge
    initial begin
        int   cnt = 0;
        txn_t held;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req) begin
                if (cnt == 0) held = '{we: mem_we, a: mem_addr, d: mem_wdata};
                cnt++;
                if (cnt == LAT) begin
                    cnt = 0;
                    check(held == {mem_we, mem_addr, mem_wdata}, "R10", "request held",
                          32'({mem_we, mem_addr}), 32'({held.we, held.a}));
                    if (mem_we) mem_img[mem_addr] = mem_wdata;
                    else        mem_rdata = mem_val(mem_addr);
                    log_q.push_back('{we: mem_we, a: mem_addr, d: mem_wdata});
                    mem_ack = 1'b1;
                end
            end
        end
    end

    // scoreboard monitor: compare each completed read against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cpu_req && cpu_ready && !cpu_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected read completion", 32'(cpu_rdata), 32'h0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(cpu_rdata == e, "R2", "read data", 32'(cpu_rdata), 32'(e));
                end
            end
        end
    end

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk);
        #2;
        log_q.delete();
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        if (we) cpu_view[a] = d;
        else    exp_q.push_back(cpu_view.exists(a) ? cpu_view[a] : dflt(a));
        stall = 0;
        forever begin
            @(negedge clk);
            if (cpu_ready) break;
            stall++;
        end
        @(posedge clk);
        #2;
        cpu_req = 1'b0;
        cpu_we = 1'b0;
    endtask

    task automatic expect_one_read(input string req, input logic [AW-1:0] a);
        check(log_q.size() == 1, req, "transaction count", 32'(log_q.size()), 32'd1);
        if (log_q.size() >= 1)
            check(log_q[0].we == 1'b0 && log_q[0].a == a, req, "refill read address",
                  32'({log_q[0].we, log_q[0].a}), 32'({1'b0, a}));
    endtask

    task automatic expect_wb_then_read(input string req, input logic [AW-1:0] va,
                                       input logic [DW-1:0] vd, input logic [AW-1:0] a);
        check(log_q.size() == 2, req, "transaction count", 32'(log_q.size()), 32'd2);
        if (log_q.size() == 2) begin
            check(log_q[0].we && log_q[0].a == va, req, "write-back address",
                  32'({log_q[0].we, log_q[0].a}), 32'({1'b1, va}));
            check(log_q[0].d == vd, req, "write-back data", 32'(log_q[0].d), 32'(vd));
            check(!log_q[1].we && log_q[1].a == a, req, "read after write-back",
                  32'({log_q[1].we, log_q[1].a}), 32'({1'b0, a}));
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        check(1'b0, "ALL", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    localparam logic [AW-1:0] A = 20'h00005;
    localparam logic [AW-1:0] B = 20'h00405;
    localparam logic [AW-1:0] C = 20'h00805;
    localparam logic [AW-1:0] D = 20'h00033;
    localparam logic [AW-1:0] E = 20'h00433;
    localparam logic [AW-1:0] F = 20'h00833;
    localparam logic [AW-1:0] Z = 20'hFFFFF;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 idle state after reset
        check(cpu_ready == 1'b1, "R1", "ready when idle", 32'(cpu_ready), 32'd1);
        check(mem_req == 1'b0, "R1", "no memory request", 32'(mem_req), 32'd0);

        // R1 / R5 / R9: cold miss
        access(1'b0, A, '0);
        expect_one_read("R5", A);
        check(stall >= LAT, "R9", "stall through miss", 32'(stall), 32'(LAT));

        // R2: read hit is immediate and silent
        access(1'b0, A, '0);
        check(stall == 0, "R2", "hit stall", 32'(stall), 32'd0);
        check(log_q.size() == 0, "R2", "hit traffic", 32'(log_q.size()), 32'd0);

        // R7 empty way taken, R3 both tags in one set
        access(1'b0, B, '0);
        expect_one_read("R7", B);
        access(1'b0, A, '0);
        check(stall == 0, "R3", "first tag still present", 32'(stall), 32'd0);
        access(1'b0, B, '0);
        check(stall == 0, "R3", "second tag present", 32'(stall), 32'd0);

        // R4 write hit: cache only
        access(1'b0, A, '0);
        access(1'b1, A, 16'h1234);
        check(stall == 0, "R4", "write hit stall", 32'(stall), 32'd0);
        check(log_q.size() == 0, "R4", "write hit traffic", 32'(log_q.size()), 32'd0);
        check(mem_val(A) == dflt(A), "R4", "memory untouched", 32'(mem_val(A)), 32'(dflt(A)));
        access(1'b0, A, '0);

        // R7 / R11: LRU picks clean B, no write-back
        access(1'b0, C, '0);
        expect_one_read("R11", C);

        // R6: LRU now picks dirty A
        access(1'b0, B, '0);
        expect_wb_then_read("R6", A, 16'h1234, B);
        check(mem_val(A) == 16'h1234, "R6", "memory updated", 32'(mem_val(A)), 32'h1234);
        access(1'b0, A, '0);

        // R8 write miss allocates then writes
        access(1'b1, D, 16'hBEEF);
        expect_one_read("R8", D);
        access(1'b0, D, '0);
        check(stall == 0, "R8", "written line resident", 32'(stall), 32'd0);
        access(1'b0, E, '0);
        expect_one_read("R7", E);
        access(1'b0, F, '0);
        expect_wb_then_read("R8", D, 16'hBEEF, F);
        access(1'b0, D, '0);

        // R1 / R3: top index and tag
        access(1'b0, Z, '0);
        expect_one_read("R1", Z);
        access(1'b0, Z, '0);
        check(stall == 0, "R3", "top index hit", 32'(stall), 32'd0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", "reads outstanding", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule